// File: doc/BRIEF.md
# Masked Associative Compare Engine

This block is a small content-addressable array. Each entry holds a data word and a valid bit and is loaded through a simple write port. A search key (the comparand) and two alternative mask words are loaded one 16-bit segment at a time. Writing the most significant segment of any of these three words starts a search, and so does a write to the control word. During a search every valid entry is compared with the key. Bit positions can be excluded from the comparison by whichever mask the control word selects.

The result of a search is registered. It consists of a per-entry hit vector and the index of the lowest-numbered matching entry, and both stay unchanged until the next search. An internal active-low match condition is derived from the hit vector. A control setting can force this condition inactive. It drives a gated, active-low match flag, enabled only while the chain-enable input is low, and an active-low cascade output that merges this array's match with the match of the upstream device in a chain.

A control write with its top bit clear does not start a search. Instead it resets the engine: it invalidates every entry, clears the control word and clears the result.

Top module: `cam_match_engine`

## Requirements
- R1: An entry write stores `ent_wr_data` and `ent_wr_valid` at `ent_wr_addr` at the clock edge. Entries written with the valid bit clear, and all entries after reset, never produce a hit.
- R2: A control write with bit 15 set stores bits 14:0 and starts a search. A control write with bit 15 clear starts no search; at the edge it clears every valid bit, the control word and the hit vector. This reset wins over an entry write or search start in the same cycle.
- R3: A segment write with `reg_wr_sel` 0 (comparand), 1 (mask 1) or 2 (mask 2) replaces bits `seg*16+15 : seg*16`. Only a write to segment 3 starts a search; select value 3 changes nothing. Without a search, the hit vector and match address hold.
- R4: A search sets a hit for entry i when entry i is valid and matches the key in every bit position whose mask bit is 0. Control bits 5:4 choose the mask: 01 selects mask 1, 10 selects mask 2, and 00 or 11 compare all bits.
- R5: The hit vector and match address update at the clock edge that ends the request cycle. The search uses the key, masks and control word as they stand after that cycle's writes, and the entry contents from before an entry write in the same cycle.
- R6: `match_addr` is the lowest index set in the hit vector, or 0 when the hit vector is empty.
- R7: The internal active-low match condition is low when any hit is set. It is forced high while control bits 14:13 equal 11.
- R8: `match_flag_n` follows the internal match condition while `chain_en_n` is low and is high while `chain_en_n` is high.
- R9: `cascade_out_n` is low when the internal match condition is low or `up_match_n` is low, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_addr | input | AW (4) | Entry index to write |
| ent_wr_data | input | WIDTH (64) | Entry data |
| ent_wr_valid | input | 1 | Valid bit stored with the entry |
| reg_wr_en | input | 1 | Segment write strobe |
| reg_wr_sel | input | 2 | 0 comparand, 1 mask 1, 2 mask 2, 3 none |
| reg_wr_seg | input | SW (2) | Segment index, 0 = least significant |
| reg_wr_data | input | SEG_W (16) | Segment data |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 16 | Control value; bit 15 clear requests a reset |
| chain_en_n | input | 1 | Active-low enable for the match flag |
| up_match_n | input | 1 | Active-low match from the upstream device |
| hit_vec | output | ENTRIES (16) | Registered per-entry hit vector |
| match_addr | output | AW (4) | Lowest matching entry index |
| match_flag_n | output | 1 | Gated active-low match flag |
| cascade_out_n | output | 1 | Active-low merged match toward the next device |

## Verification
The bench writes the three lower comparand segments and checks that no search starts before the top segment arrives. A design that launched on every segment write would show stale partial-key hits. A mask is written while unselected and must not affect the result until the control word selects it. Two identical entries must report the lower index, and an invalid entry that equals the key must stay silent; a design with a reversed priority encoder or without valid gating would report the wrong address or a phantom hit. An entry write in the same cycle as a search, the flag-disable setting with a low upstream match, and the control reset that must invalidate every entry are also covered. A random phase with a small data pool compares every output against the behavioural model on every cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CTL_W       = 15;
    localparam int CTL_RUN_BIT = 15;
    localparam int FLAG_OFF_HI = 14;
    localparam int FLAG_OFF_LO = 13;
    localparam int MSEL_HI     = 5;
    localparam int MSEL_LO     = 4;

    typedef enum logic [1:0] {
        RSEL_KEY   = 2'd0,
        RSEL_MASK1 = 2'd1,
        RSEL_MASK2 = 2'd2,
        RSEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MSEL_OFF   = 2'd0,
        MSEL_ONE   = 2'd1,
        MSEL_TWO   = 2'd2,
        MSEL_OFF_B = 2'd3
    } mask_sel_e;

endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [WIDTH-1:0]                wr_data,
    input  logic                            wr_valid,
    input  logic                            clear_all,
    output logic [ENTRIES-1:0][WIDTH-1:0]   entry_data,
    output logic [ENTRIES-1:0]              entry_valid
);

    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] data;
        logic [ENTRIES-1:0]            valid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (32'(wr_addr) < ENTRIES)) begin
            st_d.data[wr_addr]  = wr_data;
            st_d.valid[wr_addr] = wr_valid;
        end
        if (clear_all) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_data  = st_q.data;
    assign entry_valid = st_q.valid;

endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64
) (
    input  logic [WIDTH-1:0]                key,
    input  logic [WIDTH-1:0]                ignore,
    input  logic [ENTRIES-1:0][WIDTH-1:0]   entry_data,
    input  logic [ENTRIES-1:0]              entry_valid,
    output logic [ENTRIES-1:0]              hit
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_row
        logic [WIDTH-1:0] diff;
        assign diff    = (entry_data[gi] ^ key) & ~ignore;
        assign hit[gi] = entry_valid[gi] & ~(|diff);
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int ENTRIES = 16,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] req,
    output logic [AW-1:0]      idx
);

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/cam_match_engine.sv
module cam_match_engine
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    parameter int SEG_W   = 16,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int NSEG   = WIDTH / SEG_W,
    localparam int SW     = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ent_wr_en,
    input  logic [AW-1:0]      ent_wr_addr,
    input  logic [WIDTH-1:0]   ent_wr_data,
    input  logic               ent_wr_valid,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [SW-1:0]      reg_wr_seg,
    input  logic [SEG_W-1:0]   reg_wr_data,
    input  logic               ctl_wr_en,
    input  logic [15:0]        ctl_wr_data,
    input  logic               chain_en_n,
    input  logic               up_match_n,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [AW-1:0]      match_addr,
    output logic               match_flag_n,
    output logic               cascade_out_n
);

    localparam int LAST_SEG = NSEG - 1;

    typedef struct packed {
        logic [WIDTH-1:0] key;
        logic [WIDTH-1:0] mask1;
        logic [WIDTH-1:0] mask2;
        logic [CTL_W-1:0] ctl;
    } cfg_t;

    typedef struct packed {
        logic [ENTRIES-1:0] hit;
        logic [AW-1:0]      addr;
    } res_t;

    cfg_t cfg_d, cfg_q;
    res_t res_d, res_q;

    logic                          seg_launch;
    logic                          ctl_launch;
    logic                          ctl_reset;
    logic                          launch;
    logic [WIDTH-1:0]              eff_mask;
    logic [ENTRIES-1:0][WIDTH-1:0] entry_data;
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0]            hit_raw;
    logic [AW-1:0]                 prio_addr;
    logic                          flag_off;
    logic                          int_match_n;

    // next configuration: segment writes, control writes, search start
    always_comb begin
        cfg_d      = cfg_q;
        seg_launch = 1'b0;
        ctl_launch = 1'b0;
        ctl_reset  = 1'b0;
        if (reg_wr_en && (32'(reg_wr_seg) < NSEG)) begin
            unique case (reg_sel_e'(reg_wr_sel))
                RSEL_KEY:   cfg_d.key[reg_wr_seg*SEG_W +: SEG_W]   = reg_wr_data;
                RSEL_MASK1: cfg_d.mask1[reg_wr_seg*SEG_W +: SEG_W] = reg_wr_data;
                RSEL_MASK2: cfg_d.mask2[reg_wr_seg*SEG_W +: SEG_W] = reg_wr_data;
                default: ;
            endcase
            if ((reg_sel_e'(reg_wr_sel) != RSEL_NONE) && (32'(reg_wr_seg) == LAST_SEG)) begin
                seg_launch = 1'b1;
            end
        end
        if (ctl_wr_en) begin
            if (ctl_wr_data[CTL_RUN_BIT]) begin
                cfg_d.ctl  = ctl_wr_data[CTL_W-1:0];
                ctl_launch = 1'b1;
            end else begin
                cfg_d.ctl  = '0;
                ctl_reset  = 1'b1;
            end
        end
        launch = (seg_launch || ctl_launch) && !ctl_reset;

        unique case (mask_sel_e'(cfg_d.ctl[MSEL_HI:MSEL_LO]))
            MSEL_ONE: eff_mask = cfg_d.mask1;
            MSEL_TWO: eff_mask = cfg_d.mask2;
            default:  eff_mask = '0;
        endcase
    end

    cam_entry_store #(
        .ENTRIES (ENTRIES),
        .WIDTH   (WIDTH)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ent_wr_en),
        .wr_addr     (ent_wr_addr),
        .wr_data     (ent_wr_data),
        .wr_valid    (ent_wr_valid),
        .clear_all   (ctl_reset),
        .entry_data  (entry_data),
        .entry_valid (ent_valid)
    );

    cam_match_array #(
        .ENTRIES (ENTRIES),
        .WIDTH   (WIDTH)
    ) u_match (
        .key         (cfg_d.key),
        .ignore      (eff_mask),
        .entry_data  (entry_data),
        .entry_valid (ent_valid),
        .hit         (hit_raw)
    );

    cam_prio_enc #(
        .ENTRIES (ENTRIES)
    ) u_prio (
        .req (hit_raw),
        .idx (prio_addr)
    );

    // next result
    always_comb begin
        res_d = res_q;
        if (ctl_reset) begin
            res_d = '0;
        end else if (launch) begin
            res_d.hit  = hit_raw;
            res_d.addr = prio_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            res_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            res_q <= res_d;
        end
    end

    assign flag_off      = (cfg_q.ctl[FLAG_OFF_HI:FLAG_OFF_LO] == 2'b11);
    assign int_match_n   = flag_off | ~(|res_q.hit);
    assign hit_vec       = res_q.hit;
    assign match_addr    = res_q.addr;
    assign match_flag_n  = chain_en_n | int_match_n;
    assign cascade_out_n = int_match_n & up_match_n;

endmodule

// File: rtl/cam_match_engine_chk.sv
module cam_match_engine_chk #(
    parameter int ENTRIES = 16,
    parameter int AW      = 4,
    parameter int SW      = 2,
    parameter int NSEG    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [1:0]         reg_wr_sel,
    input logic [SW-1:0]      reg_wr_seg,
    input logic               ctl_wr_en,
    input logic               ctl_run,
    input logic               chain_en_n,
    input logic               up_match_n,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [AW-1:0]      match_addr,
    input logic               match_flag_n,
    input logic               cascade_out_n,
    input logic [ENTRIES-1:0] ent_valid,
    input logic               flag_off
);

    logic start_req;
    logic clear_req;
    logic [ENTRIES-1:0] below;

    assign start_req = (ctl_wr_en && ctl_run)
                    || (reg_wr_en && (reg_wr_sel != 2'd3) && (32'(reg_wr_seg) == NSEG - 1));
    assign clear_req = ctl_wr_en && !ctl_run;
    assign below     = (ENTRIES'(1) << match_addr) - ENTRIES'(1);

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (hit_vec == '0) && (ent_valid == '0));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_req && !clear_req) |=> $stable(hit_vec) && $stable(match_addr));

    a_r4_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !clear_req) |=> ((hit_vec & ~$past(ent_valid)) == '0));

    a_r6_addr_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> hit_vec[match_addr]);

    a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |-> ((hit_vec & below) == '0));

    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit_vec) |-> (match_addr == '0));

    a_r7_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
        flag_off |-> match_flag_n && (cascade_out_n == up_match_n));

    a_r8_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en_n |-> match_flag_n);

    a_r9_upstream: assert property (@(posedge clk) disable iff (!rst_n)
        !up_match_n |-> !cascade_out_n);

endmodule

bind cam_match_engine cam_match_engine_chk #(
    .ENTRIES (ENTRIES),
    .AW      (AW),
    .SW      (SW),
    .NSEG    (NSEG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_sel    (reg_wr_sel),
    .reg_wr_seg    (reg_wr_seg),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_run       (ctl_wr_data[15]),
    .chain_en_n    (chain_en_n),
    .up_match_n    (up_match_n),
    .hit_vec       (hit_vec),
    .match_addr    (match_addr),
    .match_flag_n  (match_flag_n),
    .cascade_out_n (cascade_out_n),
    .ent_valid     (ent_valid),
    .flag_off      (flag_off)
);

// File: tb/cam_match_engine_test.sv
module cam_match_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int W  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ent_wr_en = 1'b0;
    logic [3:0]    ent_wr_addr = '0;
    logic [W-1:0]  ent_wr_data = '0;
    logic          ent_wr_valid = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = '0;
    logic [1:0]    reg_wr_seg = '0;
    logic [15:0]   reg_wr_data = '0;
    logic          ctl_wr_en = 1'b0;
    logic [15:0]   ctl_wr_data = '0;
    logic          chain_en_n = 1'b0;
    logic          up_match_n = 1'b1;
    logic [N-1:0]  hit_vec;
    logic [3:0]    match_addr;
    logic          match_flag_n;
    logic          cascade_out_n;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;

    // behavioural reference state
    logic [W-1:0]  m_mem [N];
    logic [N-1:0]  m_vld = '0;
    logic [W-1:0]  m_key = '0, m_k1 = '0, m_k2 = '0;
    logic [14:0]   m_ctl = '0;
    logic [N-1:0]  m_hit = '0;
    int            m_addr = 0;

    cam_match_engine uut (
        .clk(clk), .rst_n(rst_n),
        .ent_wr_en(ent_wr_en), .ent_wr_addr(ent_wr_addr),
        .ent_wr_data(ent_wr_data), .ent_wr_valid(ent_wr_valid),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_seg(reg_wr_seg), .reg_wr_data(reg_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .chain_en_n(chain_en_n), .up_match_n(up_match_n),
        .hit_vec(hit_vec), .match_addr(match_addr),
        .match_flag_n(match_flag_n), .cascade_out_n(cascade_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update at each rising edge
    always @(posedge clk) begin
        logic [W-1:0] nk, n1, n2, msk;
        logic [14:0]  nc;
        logic         go, clr;
        if (!rst_n) begin
            m_vld = '0; m_key = '0; m_k1 = '0; m_k2 = '0;
            m_ctl = '0; m_hit = '0; m_addr = 0;
        end else begin
            nk = m_key; n1 = m_k1; n2 = m_k2; nc = m_ctl; go = 1'b0; clr = 1'b0;
            if (reg_wr_en && reg_wr_sel != 2'd3) begin
                case (reg_wr_sel)
                    2'd0: nk[reg_wr_seg*16 +: 16] = reg_wr_data;
                    2'd1: n1[reg_wr_seg*16 +: 16] = reg_wr_data;
                    default: n2[reg_wr_seg*16 +: 16] = reg_wr_data;
                endcase
                if (reg_wr_seg == 2'd3) go = 1'b1;
            end
            if (ctl_wr_en) begin
                if (ctl_wr_data[15]) begin nc = ctl_wr_data[14:0]; go = 1'b1; end
                else clr = 1'b1;
            end
            if (go && !clr) begin
                msk = (nc[5:4] == 2'b01) ? n1 : (nc[5:4] == 2'b10) ? n2 : '0;
                m_addr = -1;
                for (int i = 0; i < N; i++) begin
                    m_hit[i] = m_vld[i] && (((m_mem[i] ^ nk) & ~msk) == '0);
                    if (m_hit[i] && m_addr < 0) m_addr = i;
                end
                if (m_addr < 0) m_addr = 0;
            end
            if (ent_wr_en) begin
                m_mem[ent_wr_addr] = ent_wr_data;
                m_vld[ent_wr_addr] = ent_wr_valid;
            end
            if (clr) begin
                m_vld = '0; nc = '0; m_hit = '0; m_addr = 0;
            end
            m_key = nk; m_k1 = n1; m_k2 = n2; m_ctl = nc;
        end
    end

    // compare every cycle away from the rising edge
    always @(negedge clk) begin
        logic im;
        if (model_on) begin
            im = (m_ctl[14:13] == 2'b11) ? 1'b1 : ~(|m_hit);
            check("R4 model hit_vec", 64'(hit_vec), 64'(m_hit));
            check("R6 model match_addr", 64'(match_addr), 64'(m_addr));
            check("R8 model match_flag_n", 64'(match_flag_n), 64'(chain_en_n | im));
            check("R9 model cascade_out_n", 64'(cascade_out_n), 64'(im & up_match_n));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr_entry(int a, logic [W-1:0] d, logic v);
        ent_wr_en = 1'b1; ent_wr_addr = 4'(a); ent_wr_data = d; ent_wr_valid = v;
        step();
        ent_wr_en = 1'b0;
    endtask

    task automatic wr_seg(logic [1:0] sel, int seg, logic [15:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_seg = 2'(seg); reg_wr_data = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic wr_word(logic [1:0] sel, logic [W-1:0] d);
        for (int s = 0; s < 4; s++) wr_seg(sel, s, d[s*16 +: 16]);
    endtask

    task automatic wr_ctl(logic [15:0] d);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        step();
        ctl_wr_en = 1'b0;
    endtask

    function automatic logic [W-1:0] pat(int i);
        int j = (i == 9) ? 5 : i;
        return {16'hA000 + 16'(j), 16'h5555, 16'h00F0, 16'h1000 + 16'(j)};
    endfunction

    function automatic logic [15:0] pick();
        case ($urandom % 3)
            0: return 16'h0000;
            1: return 16'hFFFF;
            default: return 16'h1234;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        model_on = 1'b1;
        step();
        check("R2 reset hit_vec", 64'(hit_vec), 0);
        check("R6 reset match_addr", 64'(match_addr), 0);
        check("R7 reset match_flag_n", 64'(match_flag_n), 1);
        check("R9 reset cascade_out_n", 64'(cascade_out_n), 1);

        for (int i = 0; i < N; i++) wr_entry(i, pat(i), (i != 12));

        // lower segments must not launch
        for (int s = 0; s < 3; s++) wr_seg(2'd0, s, pat(5)[s*16 +: 16]);
        check("R3 no launch before top segment", 64'(hit_vec), 0);
        wr_seg(2'd0, 3, pat(5)[63:48]);
        check("R4 duplicate hits", 64'(hit_vec), 64'h0220);
        check("R6 lower duplicate wins", 64'(match_addr), 5);
        check("R7 flag low on hit", 64'(match_flag_n), 0);

        wr_word(2'd0, pat(12));
        check("R1 invalid entry silent", 64'(hit_vec), 0);

        wr_word(2'd0, pat(3));
        wr_word(2'd1, 64'hFFFF_0000_0000_FFFF);
        check("R4 unselected mask ignored", 64'(hit_vec), 64'h0008);
        wr_ctl(16'h8010);
        check("R4 mask1 selected", 64'(hit_vec), 64'hEFFF);
        check("R6 mask1 addr", 64'(match_addr), 0);
        wr_ctl(16'h8020);
        check("R4 mask2 zero", 64'(hit_vec), 64'h0008);
        wr_word(2'd2, 64'hFFFF_0000_0000_0000);
        check("R4 mask2 high seg", 64'(hit_vec), 64'h0008);
        wr_seg(2'd3, 3, 16'h0000);
        check("R3 select 3 no launch", 64'(hit_vec), 64'h0008);

        wr_ctl(16'hE010);
        check("R7 flag disabled", 64'(match_flag_n), 1);
        check("R7 cascade with upstream idle", 64'(cascade_out_n), 1);
        up_match_n = 1'b0; step();
        check("R9 upstream match passes", 64'(cascade_out_n), 0);
        up_match_n = 1'b1;
        wr_ctl(16'h8010);
        chain_en_n = 1'b1; step();
        check("R8 flag gated off", 64'(match_flag_n), 1);
        chain_en_n = 1'b0; step();
        check("R8 flag enabled", 64'(match_flag_n), 0);

        wr_entry(0, pat(0), 1'b0);
        check("R3 hold without launch", 64'(hit_vec), 64'hEFFF);
        wr_ctl(16'h8010);
        check("R6 next lowest", 64'(match_addr), 1);

        // entry write and launch in the same cycle
        ent_wr_en = 1'b1; ent_wr_addr = 4'd0; ent_wr_data = pat(0); ent_wr_valid = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_data = 16'h8010;
        step();
        ent_wr_en = 1'b0; ctl_wr_en = 1'b0;
        check("R5 old entry seen", 64'(hit_vec), 64'hEFFE);
        wr_ctl(16'h8010);
        check("R5 new entry seen next", 64'(hit_vec), 64'hEFFF);

        wr_ctl(16'h0000);
        check("R2 control reset clears hits", 64'(hit_vec), 0);
        wr_ctl(16'h8000);
        wr_word(2'd0, pat(3));
        check("R2 entries invalidated", 64'(hit_vec), 0);

        for (int c = 0; c < 3000; c++) begin
            ent_wr_en    = ($urandom % 3 == 0);
            ent_wr_addr  = 4'($urandom);
            ent_wr_data  = {pick(), pick(), pick(), pick()};
            ent_wr_valid = ($urandom % 5 != 0);
            reg_wr_en    = ($urandom % 2 == 0);
            reg_wr_sel   = 2'($urandom);
            reg_wr_seg   = 2'($urandom);
            reg_wr_data  = ($urandom % 2 == 0) ? pick() : 16'h00FF;
            ctl_wr_en    = ($urandom % 6 == 0);
            ctl_wr_data  = ($urandom % 40 == 0) ? 16'h0000
                         : {1'b1, ($urandom % 4 == 0) ? 2'b11 : 2'b00, 7'h0, 2'($urandom), 4'h0};
            chain_en_n   = ($urandom % 4 == 0);
            up_match_n   = ($urandom % 4 != 0);
            step();
        end
        ent_wr_en = 1'b0; reg_wr_en = 1'b0; ctl_wr_en = 1'b0;
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule